// File: doc/BRIEF.md
# Restartable Seconds Interval Timer

This block measures a programmed number of whole seconds and reports the end of the interval with a single-cycle pulse. It contains a free-running prescaler that divides the system clock down to a one-cycle tick per second, and a small down-counter that counts those ticks. A controller loads a duration and arms the timer with a one-cycle `start`. It then waits for `expired`. A `hold` input stops a running interval without an expiry.

Every `start` clears the prescaler, so the first tick after a start comes one full prescaler period later. The interval therefore never runs short by a partial second. After expiry the timer stays idle until the next `start`. The prescaler divisor is a parameter. Its default suits a 1.8432 MHz clock, and a bench can set a short ratio instead.

Top module: `sec_interval_timer`

## Requirements
- R1: After reset `expired` is low, and it stays low until a `start` has been accepted.
- R2: The prescaler tick is high for exactly one cycle in every DIVISOR cycles. A `start` sampled at clock edge E clears the prescaler, so the first tick decrements at edge E+DIVISOR. With duration 1, `expired` is high in the cycle that follows edge E+DIVISOR.
- R3: For a 4-bit duration N from 1 to 15 loaded at edge E, `expired` is high for the one cycle that follows edge E+N*DIVISOR, provided no other `start` or `hold` arrives in between.
- R4: A loaded duration of 0 behaves like 1: `expired` follows edge E+DIVISOR.
- R5: `expired` is high for one cycle only. It does not repeat until a new `start` has been accepted and has run its full interval.
- R6: A `start` while an interval is running restarts the timer. The new duration and a cleared prescaler take effect, and the old interval produces no expiry.
- R7: A `start` on the same edge as a tick takes priority. The duration is reloaded, the tick neither decrements nor expires, and the following tick comes DIVISOR cycles later.
- R8: `hold` high at a clock edge disarms the timer and suppresses any expiry at that edge. A `start` on the same edge as `hold` is ignored.
- R9: After a `hold` no expiry occurs, however long the timer waits, until a new `start` arms it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to load `duration` and begin timing |
| hold | input | 1 | Stops and disarms the timer while high |
| duration | input | DUR_W (4) | Interval length in seconds, sampled on `start` |
| expired | output | 1 | One-cycle pulse at the end of the interval |

## Verification
The assertions assume that `start`, `hold` and `duration` are synchronous to `clk` and change only between edges. They also assume that `start` is a pulse rather than a held level, since a held `start` would keep reloading the timer. The bench drives every input on the falling edge and keeps `start` and `hold` high for a single cycle each. It times the coincident cases by counting cycles from the preceding start. Against a behavioural model that counts the whole interval in clock cycles, the bench covers:
- a restart that lands exactly on a tick edge;
- a `hold` in the middle of an interval;
- a `start` and a `hold` on the same edge.

// File: rtl/sec_interval_timer.sv
module sec_interval_timer #(
  parameter int DIVISOR = 1843200,
  parameter int DUR_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold,
  input  logic [DUR_W-1:0] duration,
  output logic             expired
);
  localparam int PW = (DIVISOR > 1) ? $clog2(DIVISOR) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIVISOR - 1);

  logic [PW-1:0]    pre_cnt;
  logic [DUR_W-1:0] left;
  logic             armed;
  logic             tick;
  logic             last;

  assign tick = (pre_cnt == PRE_LAST);
  assign last = (left <= DUR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              pre_cnt <= '0;
    else if (start || tick)  pre_cnt <= '0;
    else                     pre_cnt <= pre_cnt + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      left    <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (hold) begin
        armed <= 1'b0;
      end else if (start) begin
        armed <= 1'b1;
        left  <= duration;
      end else if (armed && tick) begin
        if (last) begin
          expired <= 1'b1;
          armed   <= 1'b0;
          left    <= '0;
        end else begin
          left <= left - DUR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sec_interval_timer_chk.sv
module sec_interval_timer_chk #(
  parameter int DIVISOR = 10,
  parameter int PW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          hold,
  input logic          expired,
  input logic          tick,
  input logic          armed,
  input logic [PW-1:0] pre_cnt
);
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);

  assert_hold_silences_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!expired && !armed));

  assert_start_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hold) |=> (!expired && armed));

  assert_expiry_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> ($past(armed) && $past(tick) && !armed));

  assert_prescale_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt < PW'(DIVISOR));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pre_cnt == '0));

  generate
    if (DIVISOR > 1) begin : g_tick
      assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind sec_interval_timer sec_interval_timer_chk #(.DIVISOR(DIVISOR), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .hold(hold), .expired(expired),
  .tick(tick), .armed(armed), .pre_cnt(pre_cnt)
);

// File: tb/tb_sec_interval_timer.sv
module tb_sec_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 10;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       hold = 1'b0;
  logic [3:0] duration = '0;
  logic       expired;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int pulses = 0;
  string tag = "R1";

  int m_rem = 0;
  bit m_act = 0;
  bit m_exp = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sec_interval_timer #(.DIVISOR(DIV), .DUR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hold(hold),
    .duration(duration), .expired(expired)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    m_exp = 0;
    if (!rst_n) begin
      m_act = 0;
      m_rem = 0;
    end else if (hold) begin
      m_act = 0;
    end else if (start) begin
      m_rem = ((duration == 0) ? 1 : int'(duration)) * DIV;
      m_act = 1;
    end else if (m_act) begin
      m_rem = m_rem - 1;
      if (m_rem == 0) begin
        m_exp = 1;
        m_act = 0;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (expired !== m_exp) begin
      failures++;
      $display("FAIL %s cycle %0d: expired=%0b expected=%0b", tag, cycles, expired, m_exp);
    end
    if (expired === 1'b1) pulses++;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick(input logic [3:0] d);
    @(negedge clk);
    start = 1'b1;
    duration = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_pulses(input string t, input int want);
    checks++;
    if (pulses != want) begin
      failures++;
      $display("FAIL %s pulse count=%0d expected=%0d", t, pulses, want);
    end
  endtask

  initial begin
    idle(3);
    tag = "R1";
    checks++;
    if (expired !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset expired=%0b expected=0", expired);
    end
    rst_n = 1'b1;
    idle(30);
    expect_pulses("R1", 0);

    tag = "R2"; pulses = 0;
    kick(4'd1); idle(DIV + 5);
    expect_pulses("R2", 1);

    tag = "R3"; pulses = 0;
    kick(4'd3); idle(3 * DIV + 5);
    kick(4'd15); idle(15 * DIV + 5);
    kick(4'd7); idle(7 * DIV + 5);
    expect_pulses("R3", 3);

    tag = "R4"; pulses = 0;
    kick(4'd0); idle(DIV + 5);
    expect_pulses("R4", 1);

    tag = "R5"; pulses = 0;
    kick(4'd2); idle(2 * DIV + 60);
    expect_pulses("R5", 1);

    tag = "R6"; pulses = 0;
    kick(4'd5); idle(23);
    kick(4'd2); idle(2 * DIV + 5);
    expect_pulses("R6", 1);

    tag = "R7"; pulses = 0;
    kick(4'd3); idle(DIV - 2);
    kick(4'd2); idle(2 * DIV + 5);
    expect_pulses("R7", 1);

    tag = "R8"; pulses = 0;
    kick(4'd4); idle(15);
    @(negedge clk); hold = 1'b1;
    @(negedge clk); hold = 1'b0;
    idle(60);
    @(negedge clk); hold = 1'b1; start = 1'b1; duration = 4'd1;
    @(negedge clk); hold = 1'b0; start = 1'b0;
    idle(3 * DIV);
    expect_pulses("R8", 0);

    tag = "R9"; pulses = 0;
    kick(4'd1); idle(DIV - 2);
    @(negedge clk); hold = 1'b1;
    @(negedge clk); hold = 1'b0;
    idle(4 * DIV);
    expect_pulses("R9", 0);
    kick(4'd2); idle(2 * DIV + 5);
    expect_pulses("R9", 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(WATCHDOG);
    failures++;
    $display("FAIL watchdog at cycle %0d expected finish earlier", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule